// File: doc/BRIEF.md
# Effective Address Mode Decoder

This block sits in an instruction front end and turns the six-bit addressing field of an opcode into a classified operand description. When `start` is pulsed, it latches the field and the operand size in bytes. It then works out the addressing form, the register it names and how many 16-bit extension words follow the opcode for this operand. It pulls those words in through a simple request/valid handshake.

Once the last word has arrived, the block raises `dec_valid` for one cycle. The outputs then carry the mode code, the register number, the word count, the byte advance and the operand values assembled from the words: a sign-extended displacement or absolute address, and up to three 32-bit immediate results. Indexed forms are not expanded here. They finish at once, with `hand_index` set, so that a separate indexed-address unit can take over the following extension word. Encodings that have no meaning raise a one-cycle `dec_err` in place of `dec_valid`.

Top module: `ea_mode_decoder`

## Requirements
- R1: When field bits [5:4] are 00, the mode code is 0 (register direct), `reg_num` is field bits [3:0], no word is fetched, and `dec_valid` rises in the cycle after the start edge.
- R2: Field bits [5:3] of 2, 3 and 4 give mode codes 1 (indirect), 2 (post-increment) and 3 (pre-decrement), with `reg_num` = 8 + field bits [2:0] and no words.
- R3: Field bits [5:3] = 5 give mode code 4. One word is fetched, and `addr_val` is that word sign-extended to 32 bits. `reg_num` = 8 + field bits [2:0].
- R4: Field bits [5:3] = 6 give mode code 5 with `reg_num` = 8 + field bits [2:0]. Field value 073 (octal) gives mode code 9 with `reg_num` = 3. Both fetch no words and raise `hand_index` together with `dec_valid`.
- R5: Field 070 gives mode code 6 with one word sign-extended into `addr_val`. Field 071 gives mode code 7, where `addr_val` is formed from two words with the first as the upper half. For mode 7, `reg_num` is field bits [2:0].
- R6: Field 072 gives mode code 8 (program-counter relative). One word is fetched, sign-extended into `addr_val`, and `reg_num` = 2.
- R7: Field 074 gives mode code 10 (immediate). The number of words fetched is the operand size rounded up to whole words: 1 for sizes 1 and 2, then 2, 4 and 6 for sizes 4, 8 and 12.
- R8: For an immediate of size 1, `imm0` is the low byte of its word sign-extended. For size 2, `imm0` is the whole word sign-extended.
- R9: For immediate sizes 4, 8 and 12, each pair of words forms one 32-bit result, first word in the upper half, filling `imm0`, `imm1` and `imm2` in order. Results not covered by the size read zero.
- R10: Fields 075, 076 and 077, and an immediate whose size is not 1, 2, 4, 8 or 12, produce a `dec_err` pulse in the cycle after the start edge. No `dec_valid` and no word request follow.
- R11: `ext_req` is high exactly while words are outstanding, and a word is taken on each edge where `ext_req` and `ext_vld` are both high. `ext_vld` has no effect while no request is open. `dec_valid` rises in the cycle after the last word is taken.
- R12: A `start` pulse arriving while `busy` is high is ignored. The decode in progress completes unchanged.
- R13: `ext_words` reports the number of words this decode fetched, and `advance` reports twice that number in bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a decode with the current field and size |
| ea_field | input | 6 | Mode bits [5:3] and register bits [2:0] |
| op_size | input | 4 | Operand size in bytes |
| ext_req | output | 1 | Extension word wanted |
| ext_vld | input | 1 | Extension word present on `ext_word` |
| ext_word | input | 16 | Extension word data |
| busy | output | 1 | Decode in progress |
| dec_valid | output | 1 | One-cycle pulse: decode complete |
| dec_err | output | 1 | One-cycle pulse: illegal encoding |
| hand_index | output | 1 | Pulse with `dec_valid` for indexed forms |
| kind_o | output | 4 | Mode code |
| reg_num | output | 4 | Register number |
| ext_words | output | 3 | Extension words consumed |
| advance | output | 4 | Bytes consumed by extension words |
| addr_val | output | 32 | Displacement or absolute address |
| imm0 | output | 32 | First immediate result |
| imm1 | output | 32 | Second immediate result |
| imm2 | output | 32 | Third immediate result |

## Verification
A miscounted word counter shows up at the ports straight away. It either holds `ext_req` high for a cycle too long or too short, or moves `dec_valid` by a cycle relative to the last accepted word. Both of these are measured per decode, with and without gaps on `ext_vld`. A word written into the wrong slot, or a latched mode that drifts while fetching, appears at once in `addr_val` or the immediate results when `dec_valid` fires. A start taken while busy would corrupt the mode code of the running decode.

// File: rtl/ead_pkg.sv
package ead_pkg;

    localparam int EXT_WORDS_MAX = 6;
    localparam int WCNT_W        = $clog2(EXT_WORDS_MAX + 1);
    localparam int WORD_W        = 16;
    localparam int DATA_W        = 2 * WORD_W;
    localparam int IMM_RES       = EXT_WORDS_MAX / 2;
    localparam int SIZE_W        = 4;

    typedef enum logic [3:0] {
        K_DIRECT  = 4'd0,
        K_IND     = 4'd1,
        K_POSTINC = 4'd2,
        K_PREDEC  = 4'd3,
        K_DISP16  = 4'd4,
        K_INDEXED = 4'd5,
        K_ABS16   = 4'd6,
        K_ABS32   = 4'd7,
        K_PCDISP  = 4'd8,
        K_PCINDEX = 4'd9,
        K_IMM     = 4'd10
    } ea_kind_e;

    typedef struct packed {
        ea_kind_e            kind;
        logic [3:0]          regnum;
        logic [WCNT_W-1:0]   nwords;
        logic                illegal;
    } ea_dec_t;

    function automatic logic imm_size_ok(input logic [SIZE_W-1:0] sz);
        return (sz == 4'd1) || (sz == 4'd2) || (sz == 4'd4) ||
               (sz == 4'd8) || (sz == 4'd12);
    endfunction

    function automatic logic [WCNT_W-1:0] imm_word_count(input logic [SIZE_W-1:0] sz);
        logic [SIZE_W:0] rounded;
        rounded = {1'b0, sz} + {{SIZE_W{1'b0}}, 1'b1};
        return WCNT_W'(rounded >> 1);
    endfunction

    function automatic logic [DATA_W-1:0] sext16(input logic [WORD_W-1:0] w);
        return {{(DATA_W-WORD_W){w[WORD_W-1]}}, w};
    endfunction

    function automatic logic [DATA_W-1:0] sext8(input logic [7:0] b);
        return {{(DATA_W-8){b[7]}}, b};
    endfunction

endpackage

// File: rtl/ea_mode_classify.sv
module ea_mode_classify
    import ead_pkg::*;
(
    input  logic [5:0]        field,
    input  logic [SIZE_W-1:0] size,
    output ea_dec_t           dec
);
    always_comb begin
        dec.kind    = K_DIRECT;
        dec.regnum  = {1'b1, field[2:0]};
        dec.nwords  = '0;
        dec.illegal = 1'b0;
        case (field[5:3])
            3'd0, 3'd1: begin
                dec.kind   = K_DIRECT;
                dec.regnum = field[3:0];
            end
            3'd2: dec.kind = K_IND;
            3'd3: dec.kind = K_POSTINC;
            3'd4: dec.kind = K_PREDEC;
            3'd5: begin
                dec.kind   = K_DISP16;
                dec.nwords = WCNT_W'(1);
            end
            3'd6: dec.kind = K_INDEXED;
            default: begin
                dec.regnum = {1'b0, field[2:0]};
                case (field[2:0])
                    3'd0: begin
                        dec.kind   = K_ABS16;
                        dec.nwords = WCNT_W'(1);
                    end
                    3'd1: begin
                        dec.kind   = K_ABS32;
                        dec.nwords = WCNT_W'(2);
                    end
                    3'd2: begin
                        dec.kind   = K_PCDISP;
                        dec.nwords = WCNT_W'(1);
                    end
                    3'd3: dec.kind = K_PCINDEX;
                    3'd4: begin
                        dec.kind    = K_IMM;
                        dec.illegal = !imm_size_ok(size);
                        dec.nwords  = imm_size_ok(size) ? imm_word_count(size) : '0;
                    end
                    default: dec.illegal = 1'b1;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/ea_word_collector.sv
module ea_word_collector
    import ead_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start,
    input  ea_dec_t                           dec_in,
    input  logic [SIZE_W-1:0]                 size_in,
    input  logic                              ext_vld,
    input  logic [WORD_W-1:0]                 ext_word,
    output logic                              busy,
    output logic                              ext_req,
    output logic                              dec_valid,
    output logic                              dec_err,
    output ea_dec_t                           dec_q,
    output logic [SIZE_W-1:0]                 size_q,
    output logic [EXT_WORDS_MAX*WORD_W-1:0]   words
);
    logic              busy_q;
    logic [WCNT_W-1:0] cnt_q;
    logic              take_start;
    logic              take_word;
    logic              last_word;

    assign take_start = start && !busy_q;
    assign take_word  = busy_q && ext_vld;
    assign last_word  = (cnt_q == (dec_q.nwords - WCNT_W'(1)));
    assign busy       = busy_q;
    assign ext_req    = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            cnt_q     <= '0;
            dec_valid <= 1'b0;
            dec_err   <= 1'b0;
            dec_q     <= '0;
            size_q    <= '0;
        end else begin
            dec_valid <= 1'b0;
            dec_err   <= 1'b0;
            if (take_start) begin
                dec_q  <= dec_in;
                size_q <= size_in;
                cnt_q  <= '0;
                if (dec_in.illegal)
                    dec_err <= 1'b1;
                else if (dec_in.nwords == '0)
                    dec_valid <= 1'b1;
                else
                    busy_q <= 1'b1;
            end else if (take_word) begin
                cnt_q <= cnt_q + WCNT_W'(1);
                if (last_word) begin
                    busy_q    <= 1'b0;
                    dec_valid <= 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < EXT_WORDS_MAX; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || take_start)
                words[g*WORD_W +: WORD_W] <= '0;
            else if (take_word && (cnt_q == WCNT_W'(g)))
                words[g*WORD_W +: WORD_W] <= ext_word;
        end
    end

    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(dec_valid && dec_err)); // R10
    AST_ERR_FROM_START: assert property (@(posedge clk) disable iff (rst)
        dec_err |-> $past(start && !busy_q)); // R10
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q < dec_q.nwords)); // R11
    AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> ($past(busy_q && ext_vld) || $past(start && !busy_q))); // R11
    AST_DEC_HELD: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> $stable(dec_q)); // R12
endmodule

// File: rtl/ea_value_build.sv
module ea_value_build
    import ead_pkg::*;
(
    input  ea_kind_e                          kind,
    input  logic [SIZE_W-1:0]                 size,
    input  logic [EXT_WORDS_MAX*WORD_W-1:0]   words,
    output logic [DATA_W-1:0]                 addr_val,
    output logic [IMM_RES-1:0][DATA_W-1:0]    imm
);
    logic [WORD_W-1:0] w0;
    logic [WORD_W-1:0] w1;

    assign w0 = words[0 +: WORD_W];
    assign w1 = words[WORD_W +: WORD_W];

    always_comb begin
        case (kind)
            K_DISP16, K_ABS16, K_PCDISP: addr_val = sext16(w0);
            K_ABS32:                     addr_val = {w0, w1};
            default:                     addr_val = '0;
        endcase
    end

    for (genvar k = 0; k < IMM_RES; k++) begin : g_imm
        if (k == 0) begin : g_first
            always_comb begin
                if (kind != K_IMM)
                    imm[k] = '0;
                else if (size == 4'd1)
                    imm[k] = sext8(w0[7:0]);
                else if (size == 4'd2)
                    imm[k] = sext16(w0);
                else
                    imm[k] = {w0, w1};
            end
        end else begin : g_rest
            always_comb begin
                if (kind == K_IMM && int'(size) >= 4 * (k + 1))
                    imm[k] = {words[(2*k)*WORD_W +: WORD_W],
                              words[(2*k+1)*WORD_W +: WORD_W]};
                else
                    imm[k] = '0;
            end
        end
    end
endmodule

// File: rtl/ea_mode_decoder.sv
module ea_mode_decoder
    import ead_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [5:0]           ea_field,
    input  logic [SIZE_W-1:0]    op_size,
    output logic                 ext_req,
    input  logic                 ext_vld,
    input  logic [WORD_W-1:0]    ext_word,
    output logic                 busy,
    output logic                 dec_valid,
    output logic                 dec_err,
    output logic                 hand_index,
    output logic [3:0]           kind_o,
    output logic [3:0]           reg_num,
    output logic [WCNT_W-1:0]    ext_words,
    output logic [WCNT_W:0]      advance,
    output logic [DATA_W-1:0]    addr_val,
    output logic [DATA_W-1:0]    imm0,
    output logic [DATA_W-1:0]    imm1,
    output logic [DATA_W-1:0]    imm2
);
    ea_dec_t                            dec_c;
    ea_dec_t                            dec_q;
    logic [SIZE_W-1:0]                  size_q;
    logic [EXT_WORDS_MAX*WORD_W-1:0]    words;
    logic [IMM_RES-1:0][DATA_W-1:0]     imm;

    ea_mode_classify u_cls (
        .field (ea_field),
        .size  (op_size),
        .dec   (dec_c)
    );

    ea_word_collector u_col (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .dec_in    (dec_c),
        .size_in   (op_size),
        .ext_vld   (ext_vld),
        .ext_word  (ext_word),
        .busy      (busy),
        .ext_req   (ext_req),
        .dec_valid (dec_valid),
        .dec_err   (dec_err),
        .dec_q     (dec_q),
        .size_q    (size_q),
        .words     (words)
    );

    ea_value_build u_val (
        .kind     (dec_q.kind),
        .size     (size_q),
        .words    (words),
        .addr_val (addr_val),
        .imm      (imm)
    );

    assign kind_o     = dec_q.kind;
    assign reg_num    = dec_q.regnum;
    assign ext_words  = dec_q.nwords;
    assign advance    = {dec_q.nwords, 1'b0};
    assign hand_index = dec_valid &&
                        (dec_q.kind == K_INDEXED || dec_q.kind == K_PCINDEX);
    assign imm0       = imm[0];
    assign imm1       = imm[1];
    assign imm2       = imm[2];

    AST_HANDOFF_NO_WORDS: assert property (@(posedge clk) disable iff (rst)
        hand_index |-> (ext_words == '0)); // R4
    AST_REQ_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
        ext_req |-> !dec_valid); // R11
endmodule

// File: tb/ea_mode_decoder_test.sv
module ea_mode_decoder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [5:0]  ea_field = '0;
    logic [3:0]  op_size = '0;
    logic        ext_vld = 1'b0;
    logic [15:0] ext_word = '0;
    logic        ext_req, busy, dec_valid, dec_err, hand_index;
    logic [3:0]  kind_o, reg_num;
    logic [2:0]  ext_words;
    logic [3:0]  advance;
    logic [31:0] addr_val, imm0, imm1, imm2;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [15:0] wq [6];
    bit got_v, got_e, got_hand, req_seen;
    int vcyc;

    always #4 clk = ~clk;

    ea_mode_decoder uut (
        .clk(clk), .rst(rst), .start(start), .ea_field(ea_field), .op_size(op_size),
        .ext_req(ext_req), .ext_vld(ext_vld), .ext_word(ext_word), .busy(busy),
        .dec_valid(dec_valid), .dec_err(dec_err), .hand_index(hand_index),
        .kind_o(kind_o), .reg_num(reg_num), .ext_words(ext_words), .advance(advance),
        .addr_val(addr_val), .imm0(imm0), .imm1(imm1), .imm2(imm2)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", r, act, exp);
        end
    endtask

    task automatic issue(input logic [5:0] f, input logic [3:0] s, input bit stall, input bit poke);
        int idx = 0;
        got_v = 0; got_e = 0; got_hand = 0; req_seen = 0; vcyc = -1;
        @(negedge clk);
        ea_field = f; op_size = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 40; c++) begin
            if (dec_valid || dec_err) begin
                got_v = dec_valid; got_e = dec_err; got_hand = hand_index; vcyc = c;
                break;
            end
            if (ext_req) req_seen = 1;
            if (poke && c == 0) begin
                start = 1'b1; ea_field = 6'o05; op_size = 4'd4;
            end else begin
                start = 1'b0;
            end
            if (ext_req && !(stall && (c % 2 == 0)) && idx < 6) begin
                ext_vld = 1'b1; ext_word = wq[idx]; idx++;
            end else begin
                ext_vld = 1'b0; ext_word = 16'hDEAD;
            end
            @(negedge clk);
        end
        ext_vld = 1'b0; start = 1'b0;
    endtask

    task automatic t_reset;
        chk("R11 reset busy", 32'(busy), 0);
        chk("R11 reset ext_req", 32'(ext_req), 0);
        chk("R11 reset valid", 32'(dec_valid), 0);
        chk("R10 reset err", 32'(dec_err), 0);
        ext_vld = 1'b1; ext_word = 16'hFFFF;
        repeat (3) @(negedge clk);
        chk("R11 idle vld no req", 32'(ext_req), 0);
        ext_vld = 1'b0;
        wq[0] = 16'h0004;
        issue(6'o50, 4'd4, 0, 0);
        chk("R11 idle vld ignored addr", addr_val, 32'h4);
        chk("R11 latency one word", vcyc, 1);
    endtask

    task automatic t_direct;
        issue(6'o05, 4'd4, 0, 0);
        chk("R1 valid", 32'(got_v), 1);
        chk("R1 kind", 32'(kind_o), 0);
        chk("R1 reg d", 32'(reg_num), 5);
        chk("R1 latency", vcyc, 0);
        chk("R13 words direct", 32'(ext_words), 0);
        chk("R13 advance direct", 32'(advance), 0);
        issue(6'o13, 4'd4, 0, 0);
        chk("R1 reg a", 32'(reg_num), 11);
        chk("R1 no req", 32'(req_seen), 0);
    endtask

    task automatic t_indirect;
        issue(6'o22, 4'd4, 0, 0);
        chk("R2 kind ind", 32'(kind_o), 1);
        chk("R2 reg ind", 32'(reg_num), 10);
        issue(6'o37, 4'd4, 0, 0);
        chk("R2 kind post", 32'(kind_o), 2);
        chk("R2 reg post", 32'(reg_num), 15);
        issue(6'o41, 4'd4, 0, 0);
        chk("R2 kind pre", 32'(kind_o), 3);
        chk("R2 reg pre", 32'(reg_num), 9);
        chk("R2 no words", 32'(ext_words), 0);
    endtask

    task automatic t_disp;
        wq[0] = 16'h8002;
        issue(6'o53, 4'd4, 1, 0);
        chk("R3 kind", 32'(kind_o), 4);
        chk("R3 reg", 32'(reg_num), 11);
        chk("R3 addr", addr_val, 32'hFFFF8002);
        chk("R11 stall latency", vcyc, 2);
        chk("R13 words disp", 32'(ext_words), 1);
        chk("R13 advance disp", 32'(advance), 2);
    endtask

    task automatic t_indexed;
        issue(6'o64, 4'd4, 0, 0);
        chk("R4 kind idx", 32'(kind_o), 5);
        chk("R4 reg idx", 32'(reg_num), 12);
        chk("R4 hand idx", 32'(got_hand), 1);
        chk("R4 no req", 32'(req_seen), 0);
        issue(6'o73, 4'd4, 0, 0);
        chk("R4 kind pcidx", 32'(kind_o), 9);
        chk("R4 reg pcidx", 32'(reg_num), 3);
        chk("R4 hand pcidx", 32'(got_hand), 1);
        issue(6'o22, 4'd4, 0, 0);
        chk("R4 no hand ind", 32'(got_hand), 0);
    endtask

    task automatic t_abs;
        wq[0] = 16'h7FFE;
        issue(6'o70, 4'd4, 0, 0);
        chk("R5 kind abs16", 32'(kind_o), 6);
        chk("R5 reg abs16", 32'(reg_num), 0);
        chk("R5 addr abs16", addr_val, 32'h00007FFE);
        wq[0] = 16'h1234; wq[1] = 16'hABCD;
        issue(6'o71, 4'd4, 0, 0);
        chk("R5 kind abs32", 32'(kind_o), 7);
        chk("R5 reg abs32", 32'(reg_num), 1);
        chk("R5 addr abs32", addr_val, 32'h1234ABCD);
        chk("R11 two word latency", vcyc, 2);
        chk("R13 advance abs32", 32'(advance), 4);
    endtask

    task automatic t_pcdisp;
        wq[0] = 16'hFFFE;
        issue(6'o72, 4'd4, 0, 0);
        chk("R6 kind", 32'(kind_o), 8);
        chk("R6 reg", 32'(reg_num), 2);
        chk("R6 addr", addr_val, 32'hFFFFFFFE);
    endtask

    task automatic t_imm;
        wq[0] = 16'h12F0;
        issue(6'o74, 4'd1, 0, 0);
        chk("R7 kind", 32'(kind_o), 10);
        chk("R7 words byte", 32'(ext_words), 1);
        chk("R8 byte imm", imm0, 32'hFFFFFFF0);
        wq[0] = 16'h7FFF;
        issue(6'o74, 4'd2, 0, 0);
        chk("R8 word imm", imm0, 32'h00007FFF);
        wq[0] = 16'h89AB; wq[1] = 16'hCDEF;
        issue(6'o74, 4'd4, 1, 0);
        chk("R7 words long", 32'(ext_words), 2);
        chk("R9 long imm0", imm0, 32'h89ABCDEF);
        chk("R9 long imm1 zero", imm1, 32'h0);
        wq[2] = 16'h0102; wq[3] = 16'h0304;
        issue(6'o74, 4'd8, 0, 0);
        chk("R7 words dbl", 32'(ext_words), 4);
        chk("R9 dbl imm1", imm1, 32'h01020304);
        chk("R9 dbl imm2 zero", imm2, 32'h0);
        wq[4] = 16'hA5A5; wq[5] = 16'h5A5A;
        issue(6'o74, 4'd12, 0, 0);
        chk("R7 words ext", 32'(ext_words), 6);
        chk("R13 advance ext", 32'(advance), 12);
        chk("R9 ext imm0", imm0, 32'h89ABCDEF);
        chk("R9 ext imm2", imm2, 32'hA5A55A5A);
    endtask

    task automatic t_illegal;
        logic [5:0] bad [3] = '{6'o75, 6'o76, 6'o77};
        foreach (bad[i]) begin
            issue(bad[i], 4'd4, 0, 0);
            chk("R10 err", 32'(got_e), 1);
            chk("R10 no valid", 32'(got_v), 0);
            chk("R10 err latency", vcyc, 0);
        end
        issue(6'o74, 4'd3, 0, 0);
        chk("R10 bad size err", 32'(got_e), 1);
        chk("R10 bad size no req", 32'(req_seen), 0);
        @(negedge clk);
        chk("R10 err pulse ends", 32'(dec_err), 0);
    endtask

    task automatic t_busy;
        wq[0] = 16'h0BAD; wq[1] = 16'hF00D;
        issue(6'o71, 4'd4, 1, 1);
        chk("R12 kind kept", 32'(kind_o), 7);
        chk("R12 addr kept", addr_val, 32'h0BADF00D);
        @(negedge clk);
        chk("R12 no second decode", 32'(dec_valid), 0);
        chk("R11 req drops", 32'(ext_req), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_direct;
        t_indirect;
        t_disp;
        t_indexed;
        t_abs;
        t_pcdisp;
        t_imm;
        t_illegal;
        t_busy;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule